// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers seventeen interrupt causes for a small 8-bit processor core and settles them by a fixed priority. Each cause owns a request flag. Eight asynchronous pins feed the flags through synchronisers and edge detectors, and the edge direction is chosen per source. Peripheral completion pulses and a software-break strobe set the other flags directly. A cold-start entry is pending when reset is released.

A maskable request reaches the core only when its enable bit is set and the core's global disable input is low. The cold-start and break entries ignore both of these. The highest-priority forwarded request drives `irq_pend_o` and supplies its vector location on `vec_addr_o`. When the core acknowledges, the winner's flag is cleared and the vector stays frozen until the acknowledge is released. A small register port gives access to the enable, flag, polarity and control bits.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset all enables, polarity bits, control bits and flags 1..16 read zero. Flag 0 (cold start) is set, so `irq_pend_o`=1 and `vec_addr_o`=16'hFFFC.
- R2: Level k (0 = cold start ... 16 = break) has its vector low byte at 16'hFFFC-2k, with the high byte at the next address up. `vec_addr_o` carries the low-byte address of the winner.
- R3: Lower level number wins. The order is: 0 cold start, 1 pin A, 2 bus-line pin pair, 3 pin B, 4 pin C, 5 shared slot, 6 bus transfer done, 7..10 timers X, Y, 1, 2 underflow, 11 serial-1 receive, 12 serial-1 transmit, 13 counter pin 0, 14 counter pin 1, 15 conversion done, 16 break.
- R4: Levels 0 and 16 are forwarded whenever their flag is set, regardless of enables and `gmask_i`.
- R5: A level from 1 to 15 is forwarded only while its enable bit is 1 and `gmask_i` is 0. Its flag still latches while it is masked.
- R6: Each pin passes two synchronising flops before edge detection. A polarity bit of 1 selects the rising edge and 0 selects the falling edge. The opposite edge is ignored, and each qualifying edge sets the flag once, in the third clock edge after the pin changes. Pins: [0] A, [1] bus clock line, [2] bus data line, [3] B, [4] C, [5] D, [6] counter 0, [7] counter 1. Polarity bits: [0] A, [1] both bus lines, [2] B, [3] C, [4] D, [5] counter 0, [6] counter 1.
- R7: At the clock edge where `ack_i` first samples high, the flag of the current winner is cleared. `vec_addr_o` keeps that winner's vector until `ack_i` goes low.
- R8: Writing the flag registers clears each flag whose data bit is 0 and leaves flags with a 1 bit unchanged. A flag-setting event in the same cycle overrides the clear.
- R9: Serial-1 receive and transmit events (`peri_evt_i[6]`, `[7]`) set their flags only while control bit 1 is 1.
- R10: Level 5 takes the pin-D edge while control bit 0 is 0, and the serial-2 completion event (`peri_evt_i[0]`) while it is 1. The source that is not selected has no effect.
- R11: Register map, with bit b of a byte standing for the level given. Address 0: enables, b = level b+1 (levels 1..8). Address 1: enables, b = level b+9 (levels 9..15). Address 2: flags, b = level b+1. Address 3: flags, b = level b+9 (levels 9..16). Address 4: polarity. Address 5: control. Events: `peri_evt_i` [0] serial-2 done, [1] bus transfer done, [2..5] timers X, Y, 1, 2, [6] serial-1 receive, [7] serial-1 transmit, [8] conversion done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_pin_i | input | 8 | Asynchronous edge-sensed pins |
| peri_evt_i | input | 9 | Single-cycle peripheral event pulses |
| brk_i | input | 1 | Software-break strobe |
| gmask_i | input | 1 | Global interrupt disable from the core |
| ack_i | input | 1 | Interrupt acknowledge from the core |
| irq_pend_o | output | 1 | A forwarded request is pending |
| vec_addr_o | output | 16 | Low-byte address of the winner's vector |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |

## Verification
The checks assume that `ack_i` is low when reset is released, because the vector-hold property compares against the previous cycle. They also assume that peripheral events and the break strobe are single-cycle pulses, so that every flag sets only in the cycle after its event. The stimulus keeps `ack_i` low through reset and releases it for at least one cycle between acknowledges. Every event is driven high for exactly one clock on the falling edge. Pins are changed only after the synchroniser has settled and are held for several cycles, so that each change is one clean edge.

// File: rtl/irq_vec_pkg.sv
// Package: shared constants for the vectored interrupt controller.
// Assumes a fixed 17-level map; level numbers double as priority (0 highest).
package irq_vec_pkg;
    localparam int NUM_LEVELS = 17;
    localparam int LVL_W      = $clog2(NUM_LEVELS);
    localparam int NUM_PINS   = 8;
    localparam int NUM_POL    = 7;
    localparam int NUM_EVT    = 9;

    // Level numbers (priority order)
    localparam int LV_COLD   = 0;
    localparam int LV_PIN_A  = 1;
    localparam int LV_BUSPIN = 2;
    localparam int LV_PIN_B  = 3;
    localparam int LV_PIN_C  = 4;
    localparam int LV_SHARED = 5;
    localparam int LV_XFER   = 6;
    localparam int LV_TMR0   = 7;
    localparam int LV_S1_RX  = 11;
    localparam int LV_S1_TX  = 12;
    localparam int LV_CNT0   = 13;
    localparam int LV_CNT1   = 14;
    localparam int LV_CONV   = 15;
    localparam int LV_BRK    = 16;

    // Register addresses
    typedef enum logic [2:0] {
        RA_EN_LO  = 3'd0,
        RA_EN_HI  = 3'd1,
        RA_FLG_LO = 3'd2,
        RA_FLG_HI = 3'd3,
        RA_POL    = 3'd4,
        RA_CTRL   = 3'd5
    } reg_addr_e;

    // Map a pin index to the polarity bit that governs it
    function automatic int pin_pol(input int pin);
        if (pin == 0)      return 0;
        else if (pin <= 2) return 1;
        else               return pin - 1;
    endfunction
endpackage

// File: rtl/irq_edge_sync.sv
// Module: synchroniser plus selectable-edge detector for one async pin.
// Assumes: arm_i stays low until the sync chain and previous sample hold
// real pin data, so no spurious edge appears after reset.
module irq_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic rise_sel_i,
    input  logic pin_i,
    output logic edge_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              cur;

    assign cur = sync_q[STAGES-1];

    // Shift the pin through the synchroniser and keep the previous sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin_i};
            prev_q <= cur;
        end
    end

    // Report a qualifying edge for one cycle
    always_comb begin
        if (rise_sel_i) edge_o = arm_i & cur & ~prev_q;
        else            edge_o = arm_i & ~cur & prev_q;
    end
endmodule

// File: rtl/irq_flag_bank.sv
// Module: request flag storage with set-over-clear priority.
// Assumes set_i and clr_i are one-cycle requests; set wins on overlap.
module irq_flag_bank #(
    parameter int                 WIDTH     = 17,
    parameter logic [WIDTH-1:0]   RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] flag_o
);
    // Update flags: clear first, then new events override
    always_ff @(posedge clk) begin
        if (!rst_n) flag_o <= RESET_VAL;
        else        flag_o <= (flag_o & ~clr_i) | set_i;
    end
endmodule

// File: rtl/irq_prio_sel.sv
// Module: fixed-priority selector and vector address generator.
// Assumes bit 0 is the highest priority; vector steps down by 2 per level.
module irq_prio_sel #(
    parameter int          N       = 17,
    parameter int          IDX_W   = $clog2(N),
    parameter logic [15:0] TOP_LO  = 16'hFFFC
) (
    input  logic [N-1:0]     req_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [15:0]      vec_o
);
    // Pick the lowest-numbered active request
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IDX_W'(i);
        end
    end

    assign any_o = |req_i;

    // Vector low-byte address of the selected level
    assign vec_o = TOP_LO - {{(15-IDX_W){1'b0}}, idx_o, 1'b0};
endmodule

// File: rtl/irq_vec_ctrl.sv
// Module: top of the vectored priority interrupt controller.
// Collects pin edges, peripheral events and the break strobe into flags,
// masks them, selects a winner and holds its vector across acknowledge.
// Assumes ack_i is a level held by the core for the vector fetch.
module irq_vec_ctrl
    import irq_vec_pkg::*;
#(
    parameter int          SYNC_STAGES = 2,
    parameter logic [15:0] VEC_TOP_LO  = 16'hFFFC
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] ext_pin_i,
    input  logic [NUM_EVT-1:0]  peri_evt_i,
    input  logic                brk_i,
    input  logic                gmask_i,
    input  logic                ack_i,
    output logic                irq_pend_o,
    output logic [15:0]         vec_addr_o,
    input  logic                reg_we_i,
    input  logic [2:0]          reg_addr_i,
    input  logic [7:0]          reg_wdata_i,
    output logic [7:0]          reg_rdata_o
);
    localparam logic [NUM_LEVELS-1:0] NMI_MASK =
        NUM_LEVELS'((1 << LV_COLD) | (1 << LV_BRK));
    localparam logic [NUM_LEVELS-1:0] FLAG_RST = NUM_LEVELS'(1 << LV_COLD);

    logic [14:0]            en_q;
    logic [NUM_POL-1:0]     pol_q;
    logic                   sel_q;
    logic                   ser1_q;
    logic [SYNC_STAGES:0]   arm_q;
    logic [NUM_PINS-1:0]    pin_edge;
    logic [NUM_LEVELS-1:0]  set_vec;
    logic [NUM_LEVELS-1:0]  clr_vec;
    logic [NUM_LEVELS-1:0]  flag_q;
    logic [NUM_LEVELS-1:0]  fwd_vec;
    logic                   win_any;
    logic [LVL_W-1:0]       win_idx;
    logic [15:0]            win_vec;
    logic                   ack_q;
    logic [15:0]            hold_q;
    logic                   ack_take;
    reg_addr_e              ra;

    assign ra = reg_addr_e'(reg_addr_i);

    // Configuration registers written over the register port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            pol_q  <= '0;
            sel_q  <= 1'b0;
            ser1_q <= 1'b0;
        end else if (reg_we_i) begin
            case (ra)
                RA_EN_LO: en_q[7:0]  <= reg_wdata_i;
                RA_EN_HI: en_q[14:8] <= reg_wdata_i[6:0];
                RA_POL:   pol_q      <= reg_wdata_i[NUM_POL-1:0];
                RA_CTRL: begin
                    sel_q  <= reg_wdata_i[0];
                    ser1_q <= reg_wdata_i[1];
                end
                default: ;
            endcase
        end
    end

    // Hold edge detection off until the synchronisers carry pin data
    always_ff @(posedge clk) begin
        if (!rst_n) arm_q <= '0;
        else        arm_q <= {arm_q[SYNC_STAGES-1:0], 1'b1};
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam int PI = pin_pol(p);
        irq_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
            .clk        (clk),
            .rst_n      (rst_n),
            .arm_i      (arm_q[SYNC_STAGES]),
            .rise_sel_i (pol_q[PI]),
            .pin_i      (ext_pin_i[p]),
            .edge_o     (pin_edge[p])
        );
    end

    // Route every event source to its level
    always_comb begin
        set_vec            = '0;
        set_vec[LV_PIN_A]  = pin_edge[0];
        set_vec[LV_BUSPIN] = pin_edge[1] | pin_edge[2];
        set_vec[LV_PIN_B]  = pin_edge[3];
        set_vec[LV_PIN_C]  = pin_edge[4];
        set_vec[LV_SHARED] = sel_q ? peri_evt_i[0] : pin_edge[5];
        set_vec[LV_XFER]   = peri_evt_i[1];
        for (int t = 0; t < 4; t++) set_vec[LV_TMR0 + t] = peri_evt_i[2 + t];
        set_vec[LV_S1_RX]  = peri_evt_i[6] & ser1_q;
        set_vec[LV_S1_TX]  = peri_evt_i[7] & ser1_q;
        set_vec[LV_CNT0]   = pin_edge[6];
        set_vec[LV_CNT1]   = pin_edge[7];
        set_vec[LV_CONV]   = peri_evt_i[8];
        set_vec[LV_BRK]    = brk_i;
    end

    assign ack_take = ack_i & ~ack_q;

    // Gather clears from acknowledge and write-zero-to-clear accesses
    always_comb begin
        clr_vec = '0;
        if (ack_take && win_any) clr_vec[win_idx] = 1'b1;
        if (reg_we_i && ra == RA_FLG_LO) clr_vec[8:1]  = clr_vec[8:1]  | ~reg_wdata_i;
        if (reg_we_i && ra == RA_FLG_HI) clr_vec[16:9] = clr_vec[16:9] | ~reg_wdata_i;
    end

    irq_flag_bank #(.WIDTH(NUM_LEVELS), .RESET_VAL(FLAG_RST)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_vec),
        .clr_i  (clr_vec),
        .flag_o (flag_q)
    );

    // Forward non-maskable flags always, others only when enabled and unmasked
    assign fwd_vec = flag_q & (({1'b0, en_q, 1'b0} & {NUM_LEVELS{~gmask_i}}) | NMI_MASK);

    irq_prio_sel #(.N(NUM_LEVELS), .IDX_W(LVL_W), .TOP_LO(VEC_TOP_LO)) u_prio (
        .req_i (fwd_vec),
        .any_o (win_any),
        .idx_o (win_idx),
        .vec_o (win_vec)
    );

    // Capture the winner's vector at the start of acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q  <= 1'b0;
            hold_q <= VEC_TOP_LO;
        end else begin
            ack_q <= ack_i;
            if (ack_take) hold_q <= win_vec;
        end
    end

    assign irq_pend_o = win_any;
    assign vec_addr_o = ack_q ? hold_q : win_vec;

    // Register read multiplexer
    always_comb begin
        case (ra)
            RA_EN_LO:  reg_rdata_o = en_q[7:0];
            RA_EN_HI:  reg_rdata_o = {1'b0, en_q[14:8]};
            RA_FLG_LO: reg_rdata_o = flag_q[8:1];
            RA_FLG_HI: reg_rdata_o = flag_q[16:9];
            RA_POL:    reg_rdata_o = {{(8-NUM_POL){1'b0}}, pol_q};
            RA_CTRL:   reg_rdata_o = {6'b0, ser1_q, sel_q};
            default:   reg_rdata_o = 8'h00;
        endcase
    end
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
// Checker: temporal properties of the interrupt controller, bound to the top.
// Assumes ack_i is low at reset release and events are single-cycle pulses.
module irq_vec_ctrl_chk
    import irq_vec_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ack_i,
    input logic                  ack_q,
    input logic                  gmask_i,
    input logic                  irq_pend_o,
    input logic [15:0]           vec_addr_o,
    input logic [NUM_LEVELS-1:0] flag_q,
    input logic [NUM_LEVELS-1:0] set_vec,
    input logic                  win_any,
    input logic [LVL_W-1:0]      win_idx,
    input logic                  ser1_q
);
    // R7: vector frozen while acknowledge is held
    p_vec_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && ack_q) |-> $stable(vec_addr_o));

    // R7: winner's flag gone after the acknowledge edge unless re-set
    p_ack_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !ack_q && win_any && !set_vec[win_idx]) |=> !flag_q[$past(win_idx)]);

    // R4: break flag always reaches the core
    p_brk_nmi_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q[LV_BRK] |-> irq_pend_o);

    // R5: global mask silences every maskable level
    p_gmask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (gmask_i && !flag_q[LV_COLD] && !flag_q[LV_BRK]) |-> !irq_pend_o);

    // R8: an event always lands in its flag even against a clear
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((flag_q & $past(set_vec)) == $past(set_vec)));

    // R9: serial-1 receive flag cannot rise while serial-1 is deselected
    p_ser1_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser1_q && !flag_q[LV_S1_RX]) |=> !flag_q[LV_S1_RX]);
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ack_i      (ack_i),
    .ack_q      (ack_q),
    .gmask_i    (gmask_i),
    .irq_pend_o (irq_pend_o),
    .vec_addr_o (vec_addr_o),
    .flag_q     (flag_q),
    .set_vec    (set_vec),
    .win_any    (win_any),
    .win_idx    (win_idx),
    .ser1_q     (ser1_q)
);

// File: tb/test_irq_vec_ctrl.sv
// Directed bench for the vectored interrupt controller; one task per scenario.
module test_irq_vec_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ext_pin = '0;
    logic [8:0]  peri_evt = '0;
    logic        brk = 1'b0;
    logic        gmask = 1'b0;
    logic        ack = 1'b0;
    logic        pend;
    logic [15:0] vec;
    logic        we = 1'b0;
    logic [2:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    irq_vec_ctrl i_irq_vec_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_pin_i   (ext_pin),
        .peri_evt_i  (peri_evt),
        .brk_i       (brk),
        .gmask_i     (gmask),
        .ack_i       (ack),
        .irq_pend_o  (pend),
        .vec_addr_o  (vec),
        .reg_we_i    (we),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata)
    );

    // Record one check
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic pulse_evt(input int idx);
        @(negedge clk);
        peri_evt[idx] = 1'b1;
        @(negedge clk);
        peri_evt[idx] = 1'b0;
    endtask

    // Acknowledge once, checking the vector at entry and during hold
    task automatic ack_once(input logic [15:0] exp, input string req);
        @(negedge clk);
        ack = 1'b1;
        #1 chk(vec == exp, req, vec, exp);
        @(negedge clk);
        chk(vec == exp, "R7 hold", vec, exp);
        @(negedge clk);
        chk(vec == exp, "R7 hold", vec, exp);
        ack = 1'b0;
        @(negedge clk);
    endtask

    task automatic clear_all();
        bus_wr(3'd2, 8'h00);
        bus_wr(3'd3, 8'h00);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk(pend == 1'b1, "R1 pend", pend, 1);
        chk(vec == 16'hFFFC, "R1 vec", vec, 16'hFFFC);
        bus_rd(3'd2, d); chk(d == 8'h00, "R1 flags lo", d, 0);
        bus_rd(3'd0, d); chk(d == 8'h00, "R1 enables", d, 0);
        bus_rd(3'd5, d); chk(d == 8'h00, "R1 ctrl", d, 0);
        // R7: ack cold start, then nothing pending but vector held
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        chk(pend == 1'b0, "R7 cleared", pend, 0);
        chk(vec == 16'hFFFC, "R7 hold", vec, 16'hFFFC);
        ack = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_priority();
        bus_wr(3'd0, 8'hFF);
        bus_wr(3'd1, 8'h7F);
        @(negedge clk);
        peri_evt[2] = 1'b1; peri_evt[4] = 1'b1; peri_evt[1] = 1'b1;
        @(negedge clk);
        peri_evt = '0;
        chk(pend == 1'b1, "R3 pend", pend, 1);
        ack_once(16'hFFF0, "R3 level6 first / R2");
        ack_once(16'hFFEE, "R3 level7 second / R2");
        ack_once(16'hFFEA, "R3 level9 third / R2");
        chk(pend == 1'b0, "R7 all cleared", pend, 0);
    endtask

    task automatic t_mask();
        logic [7:0] d;
        gmask = 1'b1;
        pulse_evt(1);
        chk(pend == 1'b0, "R5 gmask blocks", pend, 0);
        bus_rd(3'd2, d); chk(d == 8'h20, "R5 flag latched", d, 8'h20);
        gmask = 1'b0;
        #1 chk(pend == 1'b1 && vec == 16'hFFF0, "R5 unmasked", vec, 16'hFFF0);
        bus_wr(3'd0, 8'hDF);
        chk(pend == 1'b0, "R5 enable off", pend, 0);
        bus_wr(3'd0, 8'hFF);
        bus_wr(3'd2, 8'hDF);
        bus_rd(3'd2, d); chk(d == 8'h00, "R8 w0c", d, 0);
    endtask

    task automatic t_nmi();
        gmask = 1'b1;
        bus_wr(3'd0, 8'h00);
        bus_wr(3'd1, 8'h00);
        @(negedge clk); brk = 1'b1;
        @(negedge clk); brk = 1'b0;
        chk(pend == 1'b1, "R4 break pend", pend, 1);
        ack_once(16'hFFDC, "R4 break vec / R2");
        gmask = 1'b0;
        bus_wr(3'd0, 8'hFF);
        bus_wr(3'd1, 8'h7F);
    endtask

    task automatic t_pins();
        logic [7:0] d;
        bus_wr(3'd4, 8'h13);   // A rising, bus lines rising, D rising
        @(negedge clk); ext_pin[0] = 1'b1;
        repeat (2) @(negedge clk);
        bus_rd(3'd2, d); chk(d[0] == 1'b0, "R6 not before 3rd edge", d, 0);
        @(negedge clk);
        bus_rd(3'd2, d); chk(d == 8'h01, "R6 rising sets", d, 1);
        chk(vec == 16'hFFFA, "R2 level1 vec", vec, 16'hFFFA);
        clear_all();
        @(negedge clk); ext_pin[0] = 1'b0;
        repeat (5) @(negedge clk);
        bus_rd(3'd2, d); chk(d == 8'h00, "R6 falling ignored", d, 0);
        bus_wr(3'd4, 8'h12);   // A now falling
        @(negedge clk); ext_pin[0] = 1'b1;
        repeat (5) @(negedge clk);
        bus_rd(3'd2, d); chk(d == 8'h00, "R6 rising ignored", d, 0);
        @(negedge clk); ext_pin[0] = 1'b0;
        repeat (5) @(negedge clk);
        bus_rd(3'd2, d); chk(d == 8'h01, "R6 falling sets once", d, 1);
        clear_all();
        repeat (3) @(negedge clk);
        bus_rd(3'd2, d); chk(d == 8'h00, "R6 no repeat", d, 0);
        @(negedge clk); ext_pin[2] = 1'b1;
        repeat (5) @(negedge clk);
        bus_rd(3'd2, d); chk(d == 8'h02, "R6 bus data line", d, 2);
        chk(vec == 16'hFFF8, "R2 level2 vec", vec, 16'hFFF8);
        clear_all();
    endtask

    task automatic t_set_wins();
        logic [7:0] d;
        bus_wr(3'd2, 8'hFF);
        pulse_evt(3);   // level 8
        @(negedge clk);
        we = 1'b1; addr = 3'd2; wdata = 8'h00;
        peri_evt[2] = 1'b1;
        @(negedge clk);
        we = 1'b0; peri_evt = '0;
        bus_rd(3'd2, d); chk(d == 8'h40, "R8 set beats clear", d, 8'h40);
        clear_all();
    endtask

    task automatic t_serial1();
        logic [7:0] d;
        pulse_evt(6);
        bus_rd(3'd3, d); chk(d == 8'h00, "R9 rx blocked", d, 0);
        bus_wr(3'd5, 8'h02);
        pulse_evt(6);
        bus_rd(3'd3, d); chk(d == 8'h04, "R9 rx accepted", d, 4);
        chk(vec == 16'hFFE6, "R2 level11 vec", vec, 16'hFFE6);
        clear_all();
        bus_wr(3'd5, 8'h00);
    endtask

    task automatic t_shared();
        logic [7:0] d;
        pulse_evt(0);
        bus_rd(3'd2, d); chk(d == 8'h00, "R10 serial2 ignored", d, 0);
        @(negedge clk); ext_pin[5] = 1'b1;
        repeat (5) @(negedge clk);
        bus_rd(3'd2, d); chk(d == 8'h10, "R10 pin D selected", d, 8'h10);
        chk(vec == 16'hFFF2, "R2 level5 vec", vec, 16'hFFF2);
        clear_all();
        bus_wr(3'd5, 8'h01);
        @(negedge clk); ext_pin[5] = 1'b0;
        @(negedge clk); ext_pin[5] = 1'b1;
        repeat (5) @(negedge clk);
        bus_rd(3'd2, d); chk(d == 8'h00, "R10 pin D ignored", d, 0);
        pulse_evt(0);
        bus_rd(3'd2, d); chk(d == 8'h10, "R10 serial2 selected", d, 8'h10);
        clear_all();
        bus_rd(3'd1, d); chk(d == 8'h7F, "R11 enable hi readback", d, 8'h7F);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_priority();
        t_mask();
        t_nmi();
        t_pins();
        t_set_wins();
        t_serial1();
        t_shared();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule